// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is one pulse-width-modulated output channel with a small register port. Software sets a period and a high time, both counted in ticks of a count clock. The count clock is the input clock divided by a power of two. The channel then drives a repeating waveform: high for the first part of each period and low for the rest. The converting of time units into counts is left entirely to software.

New settings do not act at once while the channel runs. Each register write lands in a shadow copy. The active copy takes the shadow values only at the end of a period, or straight away while the channel is stopped. A hold bit keeps the shadow values back, so that a period, a high time and a divider that belong together are committed as one set. The block refuses two settings that would make the waveform undefined: a zero period and a zero high time. It refuses them both when the channel is started and when new values are committed.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset both registers read as 0 and `pwm_out` is low.
- R2: The control register is at byte offset 0x0. Its run bit is bit 0 and an auxiliary bit is bit 4. The hold bit is bit 11, the divider half-step bit is bit 15 and the 4-bit divider select is bits 19:16. All these bits read back, and every other bit reads as 0. The auxiliary bit has no effect on the output. Any offset other than 0x0 and 0x4 reads as 0.
- R3: The count register is at byte offset 0x4. It holds the 10-bit period in bits 25:16 and the 10-bit high time in bits 9:0, and reads back the last value written (the shadow copy).
- R4: The divider exponent is e = 2*select + half-step, limited to at most 24. One count tick takes 2^e input clock cycles.
- R5: While running with period P and high time H (H < P), `pwm_out` is high for the first H*2^e cycles of each P*2^e-cycle period, counted from the clock edge that starts the channel, and low for the rest.
- R6: If H >= P, `pwm_out` stays high while the channel runs.
- R7: While the hold bit is 1, register writes change only the shadow copy, and the active waveform does not change.
- R8: With hold at 0, the shadow copy becomes active at the end of the current period while the channel runs, or in the next cycle while it is stopped.
- R9: A control write that sets the run bit is refused when the active or shadow period or high time is zero. The run bit then reads 0 and `pwm_out` stays low.
- R10: A control write with the run bit at 0 drives `pwm_out` low from the next cycle. The next start begins a fresh period at its high phase.
- R11: While the channel runs, a commit at a period end is withheld when the shadow period or high time is zero, and the old waveform continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | PWM waveform |

## Verification
A register write can fall in the same cycle as the clock edge that ends a period. The commit then has to take the shadow values from before that write, and the write must wait for the following period end. The bench provokes this by sweeping the moment of a count-register write across several period ends while the channel runs, and by starting and stopping the channel near a boundary. A behavioural model predicts the output and the read data for every clock, and the bench compares them against the design.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;
    localparam int CNT_W    = 10;
    localparam int SEL_W    = 4;
    localparam int DEXP_W   = SEL_W + 1;
    localparam int DEXP_MAX = 24;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h4;

    localparam int B_RUN    = 0;
    localparam int B_AUX    = 4;
    localparam int B_HOLD   = 11;
    localparam int B_HALF   = 15;
    localparam int B_SEL    = 16;
    localparam int B_PER    = 16;
    localparam int B_HI     = 0;

    typedef struct packed {
        logic [CNT_W-1:0]  per;
        logic [CNT_W-1:0]  hi;
        logic [DEXP_W-1:0] dexp;
    } tcfg_t;

    function automatic logic cfg_ok(tcfg_t c);
        return (c.per != '0) && (c.hi != '0);
    endfunction
endpackage

// File: rtl/pwm_timer_regs.sv
`timescale 1ns/1ps
module pwm_timer_regs
    import pwm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              run_q,
    output tcfg_t             shadow,
    output logic              hold,
    output logic              ctrl_wr,
    output logic              run_req,
    output logic [DATA_W-1:0] bus_rdata
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             half;
        logic             hold;
        logic             aux;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] hi;
    } rstate_t;

    rstate_t st_d, st_q;
    logic    count_wr;
    logic [DEXP_W-1:0] raw_exp;

    always_comb begin
        st_d     = st_q;
        ctrl_wr  = bus_we && (bus_addr == OFS_CTRL);
        count_wr = bus_we && (bus_addr == OFS_COUNT);
        if (ctrl_wr) begin
            st_d.sel  = bus_wdata[B_SEL +: SEL_W];
            st_d.half = bus_wdata[B_HALF];
            st_d.hold = bus_wdata[B_HOLD];
            st_d.aux  = bus_wdata[B_AUX];
        end
        if (count_wr) begin
            st_d.per = bus_wdata[B_PER +: CNT_W];
            st_d.hi  = bus_wdata[B_HI +: CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        raw_exp     = {st_q.sel, st_q.half};
        shadow.per  = st_q.per;
        shadow.hi   = st_q.hi;
        shadow.dexp = (raw_exp > DEXP_W'(DEXP_MAX)) ? DEXP_W'(DEXP_MAX) : raw_exp;
        hold        = st_q.hold;
        run_req     = bus_wdata[B_RUN];
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[B_SEL +: SEL_W] = st_q.sel;
                bus_rdata[B_HALF]         = st_q.half;
                bus_rdata[B_HOLD]         = st_q.hold;
                bus_rdata[B_AUX]          = st_q.aux;
                bus_rdata[B_RUN]          = run_q;
            end
            OFS_COUNT: begin
                bus_rdata[B_PER +: CNT_W] = st_q.per;
                bus_rdata[B_HI +: CNT_W]  = st_q.hi;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwm_timer_presc.sv
`timescale 1ns/1ps
module pwm_timer_presc #(
    parameter int PRE_W  = 24,
    parameter int DEXP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DEXP_W-1:0] dexp,
    output logic              tick,
    output logic [PRE_W-1:0]  pre_val,
    output logic [PRE_W-1:0]  pre_lim
);
    localparam int LIM_W = PRE_W + 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pstate_t;

    pstate_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        pre_lim = PRE_W'((LIM_W'(1) << dexp) - LIM_W'(1));
        tick    = run && (st_q.cnt == pre_lim);
        if (!run)      st_d.cnt = '0;
        else if (tick) st_d.cnt = '0;
        else           st_d.cnt = st_q.cnt + PRE_W'(1);
        pre_val = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_timer_period.sv
`timescale 1ns/1ps
module pwm_timer_period #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] hi,
    output logic             wrap,
    output logic             level,
    output logic [CNT_W-1:0] cnt_val
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cstate_t;

    cstate_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        wrap  = tick && (st_q.cnt == per - CNT_W'(1));
        if (!run)      st_d.cnt = '0;
        else if (wrap) st_d.cnt = '0;
        else if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
        level   = run && (st_q.cnt < hi);
        cnt_val = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_timer_chan.sv
`timescale 1ns/1ps
module pwm_timer_chan
    import pwm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);
    typedef struct packed {
        logic  run;
        tcfg_t act;
    } tstate_t;

    tstate_t st_d, st_q;
    tcfg_t   shadow;
    logic    hold_now, ctrl_wr, run_req;
    logic    tick, wrap, level, allow, commit;
    logic [DEXP_MAX-1:0] pre_val, pre_lim;
    logic [CNT_W-1:0]    cnt_val;
    logic    run_now;
    tcfg_t   act_now;

    pwm_timer_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .run_q     (st_q.run),
        .shadow    (shadow),
        .hold      (hold_now),
        .ctrl_wr   (ctrl_wr),
        .run_req   (run_req),
        .bus_rdata (bus_rdata)
    );

    pwm_timer_presc #(.PRE_W(DEXP_MAX), .DEXP_W(DEXP_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.run),
        .dexp    (st_q.act.dexp),
        .tick    (tick),
        .pre_val (pre_val),
        .pre_lim (pre_lim)
    );

    pwm_timer_period #(.CNT_W(CNT_W)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.run),
        .tick    (tick),
        .per     (st_q.act.per),
        .hi      (st_q.act.hi),
        .wrap    (wrap),
        .level   (level),
        .cnt_val (cnt_val)
    );

    always_comb begin
        st_d   = st_q;
        allow  = cfg_ok(st_q.act) && cfg_ok(shadow);
        commit = !hold_now && (!st_q.run || (wrap && cfg_ok(shadow)));
        if (commit) st_d.act = shadow;
        if (ctrl_wr) begin
            if (run_req) st_d.run = st_q.run || allow;
            else         st_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_out = level;
    assign run_now = st_q.run;
    assign act_now = st_q.act;
endmodule

// File: rtl/pwm_timer_chk.sv
`timescale 1ns/1ps
module pwm_timer_chk
    import pwm_timer_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [3:0]          bus_addr,
    input logic                bus_we,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic                pwm_out,
    input logic                run_now,
    input logic                hold_now,
    input tcfg_t               act_now,
    input logic [CNT_W-1:0]    cnt_val,
    input logic [DEXP_MAX-1:0] pre_val,
    input logic [DEXP_MAX-1:0] pre_lim
);
    localparam logic [31:0] CTRL_USED = 32'h000F_8811;

    AST_LOW_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CTRL && !bus_wdata[B_RUN]) |=> !pwm_out); // R10

    AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run_now |-> (act_now.per != '0 && act_now.hi != '0)); // R9

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        hold_now |=> $stable(act_now)); // R7

    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> (cnt_val == '0)); // R5

    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_val <= pre_lim); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTRL) |-> ((bus_rdata & ~CTRL_USED) == '0)); // R2
endmodule

bind pwm_timer_chan pwm_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .run_now   (run_now),
    .hold_now  (hold_now),
    .act_now   (act_now),
    .cnt_val   (cnt_val),
    .pre_val   (pre_val),
    .pre_lim   (pre_lim)
);

// File: tb/sim_pwm_timer_chan.sv
`timescale 1ns/1ps
module sim_pwm_timer_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int errs = 0;
    string cur_req = "R1";
    bit done = 0;

    always #4 clk = ~clk;

    pwm_timer_chan u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // behavioural reference model
    int m_run, m_hold, m_sel, m_half, m_aux, m_sp, m_sh, m_ap, m_ah, m_ad, m_pre, m_cnt;

    function automatic int sh_exp();
        int e = 2 * m_sel + m_half;
        return (e > 24) ? 24 : e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_hold = 0; m_sel = 0; m_half = 0; m_aux = 0;
            m_sp = 0; m_sh = 0; m_ap = 0; m_ah = 0; m_ad = 0; m_pre = 0; m_cnt = 0;
        end else begin
            bit tk, bnd, cm, ok;
            int nd;
            tk  = (m_run != 0) && (m_pre == (1 << m_ad) - 1);
            bnd = tk && (m_cnt == m_ap - 1);
            cm  = (m_hold == 0) && ((m_run == 0) || (bnd && m_sp != 0 && m_sh != 0));
            ok  = m_ap != 0 && m_ah != 0 && m_sp != 0 && m_sh != 0;
            nd  = sh_exp();
            if (m_run == 0) begin m_pre = 0; m_cnt = 0; end
            else if (tk) begin m_pre = 0; m_cnt = bnd ? 0 : m_cnt + 1; end
            else m_pre = m_pre + 1;
            if (cm) begin m_ap = m_sp; m_ah = m_sh; m_ad = nd; end
            if (bus_we && bus_addr == 4'h0) begin
                m_run  = bus_wdata[0] ? ((m_run != 0 || ok) ? 1 : 0) : 0;
                m_hold = bus_wdata[11];
                m_half = bus_wdata[15];
                m_sel  = int'(bus_wdata[19:16]);
                m_aux  = bus_wdata[4];
            end
            if (bus_we && bus_addr == 4'h4) begin
                m_sp = int'(bus_wdata[25:16]);
                m_sh = int'(bus_wdata[9:0]);
            end
        end
    end

    function automatic logic [31:0] model_rd(logic [3:0] a);
        if (a == 4'h0)
            return (32'(m_sel) << 16) | (32'(m_half) << 15) | (32'(m_hold) << 11) |
                   (32'(m_aux) << 4) | 32'(m_run);
        if (a == 4'h4) return (32'(m_sp) << 16) | 32'(m_sh);
        return 32'h0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk(cur_req, {31'b0, pwm_out}, {31'b0, (m_run != 0) && (m_cnt < m_ah)});
            chk(cur_req, bus_rdata, model_rd(bus_addr));
        end
    end

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    function automatic logic [31:0] ctl(int sel, int half, int hold, int aux, int run);
        return (32'(sel) << 16) | (32'(half) << 15) | (32'(hold) << 11) | (32'(aux) << 4) | 32'(run);
    endfunction

    function automatic logic [31:0] cntw(int p, int h);
        return (32'(p) << 16) | 32'(h);
    endfunction

    // samples out waveform from the cycle after the start edge
    task automatic wave(string req, int p, int h, int e, int n);
        for (int k = 0; k < n; k++) begin
            int pos = k % (p << e);
            chk(req, {31'b0, pwm_out}, {31'b0, pos < (h << e)});
            @(negedge clk);
        end
    endtask

    task automatic count_high(int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out) c++;
        end
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        rd_chk("R1", 4'h0, 32'h0);
        rd_chk("R1", 4'h4, 32'h0);
        chk("R1", {31'b0, pwm_out}, 32'h0);

        // R9 start refused while everything is zero
        cur_req = "R9";
        wr(4'h0, ctl(0, 0, 0, 0, 1));
        rd_chk("R9", 4'h0, 32'h0);
        wr(4'h4, cntw(5, 0));
        repeat (2) @(negedge clk);
        wr(4'h0, ctl(0, 0, 0, 0, 1));
        rd_chk("R9", 4'h0, 32'h0);
        chk("R9", {31'b0, pwm_out}, 32'h0);

        // R3 count layout, reserved bits dropped
        cur_req = "R3";
        wr(4'h4, 32'hFFFF_FFFF);
        rd_chk("R3", 4'h4, 32'h03FF_03FF);
        rd_chk("R2", 4'h8, 32'h0);

        // R5 basic waveform, e = 0
        cur_req = "R5";
        wr(4'h4, cntw(5, 2));
        @(negedge clk);
        bus_addr = 4'h0; bus_we = 1'b1; bus_wdata = ctl(0, 0, 0, 0, 1);
        @(negedge clk);
        bus_we = 1'b0;
        wave("R5", 5, 2, 0, 23);

        // R10 stop mid-period, then fresh start
        cur_req = "R10";
        wr(4'h0, ctl(0, 0, 0, 0, 0));
        chk("R10", {31'b0, pwm_out}, 32'h0);
        // R4 divider e = 3 via select 1, half-step 1; committed at once while stopped (R8)
        cur_req = "R4";
        wr(4'h4, cntw(3, 1));
        wr(4'h0, ctl(1, 1, 0, 0, 0));
        @(negedge clk);
        bus_addr = 4'h0; bus_we = 1'b1; bus_wdata = ctl(1, 1, 0, 0, 1);
        @(negedge clk);
        bus_we = 1'b0;
        wave("R4", 3, 1, 3, 50);
        rd_chk("R4", 4'h0, 32'h0001_8001);

        // R6 high time above period, with auxiliary bit set (R2)
        cur_req = "R6";
        wr(4'h0, ctl(0, 1, 0, 1, 0));
        wr(4'h4, cntw(3, 7));
        @(negedge clk);
        bus_addr = 4'h0; bus_we = 1'b1; bus_wdata = ctl(0, 1, 0, 1, 1);
        @(negedge clk);
        bus_we = 1'b0;
        wave("R6", 1, 1, 0, 20);
        rd_chk("R2", 4'h0, 32'h0000_8011);

        // R7 hold keeps active values
        cur_req = "R7";
        wr(4'h0, ctl(0, 0, 0, 0, 0));
        wr(4'h4, cntw(5, 2));
        wr(4'h0, ctl(0, 0, 0, 0, 1));
        wr(4'h0, ctl(0, 0, 1, 0, 1));
        wr(4'h4, cntw(8, 6));
        rd_chk("R3", 4'h4, cntw(8, 6));
        repeat (12) @(negedge clk);
        count_high(10, c);
        chk("R7", 32'(c), 32'd4);
        // R8 release: new set after the next period end
        cur_req = "R8";
        wr(4'h0, ctl(0, 0, 0, 0, 1));
        repeat (10) @(negedge clk);
        count_high(16, c);
        chk("R8", 32'(c), 32'd12);

        // R11 zero high time withheld while running
        cur_req = "R11";
        wr(4'h4, cntw(6, 0));
        repeat (20) @(negedge clk);
        count_high(16, c);
        chk("R11", 32'(c), 32'd12);

        // R8 write swept across period ends
        cur_req = "R8";
        wr(4'h4, cntw(3, 1));
        for (int off = 0; off < 8; off++) begin
            repeat (off) @(negedge clk);
            wr(4'h4, (off % 2 == 0) ? cntw(4, 2) : cntw(3, 1));
        end
        repeat (12) @(negedge clk);

        // R2 all ones into control while stopped
        cur_req = "R2";
        wr(4'h0, 32'h0);
        wr(4'h0, 32'hFFFF_FFFF);
        rd_chk("R2", 4'h0, 32'h000F_8811);
        // R4 saturated exponent: first tick is far away, output stays high
        cur_req = "R4";
        wr(4'h0, ctl(15, 1, 0, 0, 0));
        wr(4'h4, cntw(2, 1));
        @(negedge clk);
        bus_addr = 4'h0; bus_we = 1'b1; bus_wdata = ctl(15, 1, 0, 0, 1);
        @(negedge clk);
        bus_we = 1'b0;
        count_high(60, c);
        chk("R4", 32'(c), 32'd60);
        wr(4'h0, 32'h0);
        chk("R10", {31'b0, pwm_out}, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            done = 1;
            checks++;
            errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule